// File: doc/BRIEF.md
# APB Level Interrupt Aggregator

This block gathers a parameterised number of level-sensitive interrupt lines, between 2 and 64, and merges them into one request line for a parent processor or controller. Software reaches it through an APB slave port. The port holds a per-source enable register and a per-source mask register. Each register is split into a low 32-bit word and a high 32-bit word. A read-only final status word shows which sources are at the same time high, enabled and not masked.

Each source line passes through a two-stage synchroniser before the status logic uses it. The request output is the OR of every final status bit, taken through one flop so that it cannot glitch. Enable and mask bits for sources at or above the configured count have no storage and always read as zero. Software can therefore find the source count by writing all ones to the enable words and reading them back. Writing all ones to both enable and mask is a safe start state: every source is enabled and every source is held back.

Top module: `irq_agg_apb`

## Requirements
- R1: After reset, both enable words, both mask words and both status words read 0, and `irq_out` is low.
- R2: The enable words sit at offset 0x00 (sources 0 to 31, bit i is source i) and 0x04 (sources 32 to 63, bit i is source 32+i). An APB write stores the data in the implemented bits, and a read returns them.
- R3: The mask words sit at offset 0x08 (sources 0 to 31) and 0x0C (sources 32 to 63), with the same bit layout as the enable words. They are written and read the same way as the enable words.
- R4: The status words sit at offset 0x30 (sources 0 to 31) and 0x34 (sources 32 to 63). A status bit is 1 exactly when the synchronised source is high, its enable bit is 1 and its mask bit is 0. A change on a source line reaches status after two rising clock edges.
- R5: A mask bit of 1 forces that source's status bit to 0 whatever its level and enable. A mask bit of 0 lets the source through.
- R6: Enable and mask bits for source numbers at or above `NUM_SRC` read as 0, even after ones are written to them.
- R7: A status bit stays 1 for as long as its source is high, and clears on its own when the source falls. Writes to the status offsets have no effect.
- R8: With all ones written to both enable and both mask words, every status bit reads 0 and `irq_out` stays low, even with all sources high.
- R9: `irq_out` equals the OR of all status bits one clock later. A source edge therefore reaches `irq_out` on the third rising edge after it.
- R10: `pready` is always 1 and `pslverr` is always 0. Reads of offsets not listed above return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the APB port and all state |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid while `psel` is high |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_src | input | NUM_SRC | Level-sensitive interrupt source lines |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
A corrupted enable or mask bit shows up in the very next read of that word. On a high source it also shows up in the status word, and in `irq_out` one cycle later. A fault in the synchroniser shows as a shift in the exact cycle where `irq_out` rises or falls relative to a source edge. The bench therefore samples `irq_out` both two and three edges after each edge. Storage that leaks into bits above the source count shows the first time all ones are read back.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned MAX_SRC   = 64;
    localparam int unsigned NUM_WORDS = MAX_SRC / WORD_W;
    localparam int unsigned STRIDE    = 4;

    // byte offsets of the first word of each register pair
    localparam int unsigned OFS_EN  = 'h00;
    localparam int unsigned OFS_MSK = 'h08;
    localparam int unsigned OFS_ST  = 'h30;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN_LO,
        SEL_EN_HI,
        SEL_MSK_LO,
        SEL_MSK_HI,
        SEL_ST_LO,
        SEL_ST_HI
    } reg_sel_e;

    typedef struct packed {
        logic [MAX_SRC-1:0] en;
        logic [MAX_SRC-1:0] msk;
    } ctl_t;

    // one bit per implemented source
    function automatic logic [MAX_SRC-1:0] impl_bits(int n);
        logic [MAX_SRC-1:0] r;
        for (int i = 0; i < int'(MAX_SRC); i++) begin
            r[i] = (i < n);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [WORD_W-1:0] pwdata,
    input  logic [MAX_SRC-1:0] fin,
    output logic [WORD_W-1:0] prdata,
    output ctl_t              ctl
);
    localparam logic [MAX_SRC-1:0] IMPL = impl_bits(NUM_SRC);

    logic [MAX_SRC-1:0] en_vec;
    logic [MAX_SRC-1:0] msk_vec;
    logic               wr_acc;
    reg_sel_e           sel;
    logic [WORD_W-1:0]  rd_mux;

    assign wr_acc = psel & penable & pwrite;

    always_comb begin
        sel = SEL_NONE;
        if (paddr == ADDR_W'(OFS_EN))               sel = SEL_EN_LO;
        else if (paddr == ADDR_W'(OFS_EN + STRIDE))  sel = SEL_EN_HI;
        else if (paddr == ADDR_W'(OFS_MSK))          sel = SEL_MSK_LO;
        else if (paddr == ADDR_W'(OFS_MSK + STRIDE)) sel = SEL_MSK_HI;
        else if (paddr == ADDR_W'(OFS_ST))           sel = SEL_ST_LO;
        else if (paddr == ADDR_W'(OFS_ST + STRIDE))  sel = SEL_ST_HI;
    end

    for (genvar w = 0; w < int'(NUM_WORDS); w++) begin : g_word
        localparam logic [WORD_W-1:0] KEEP = IMPL[w*WORD_W +: WORD_W];
        logic [WORD_W-1:0] en_r;
        logic [WORD_W-1:0] msk_r;
        logic              hit_en;
        logic              hit_msk;

        assign hit_en  = wr_acc && (paddr == ADDR_W'(OFS_EN  + STRIDE * w));
        assign hit_msk = wr_acc && (paddr == ADDR_W'(OFS_MSK + STRIDE * w));

        always_ff @(posedge clk) begin
            if (rst) begin
                en_r  <= '0;
                msk_r <= '0;
            end else begin
                if (hit_en)  en_r  <= pwdata & KEEP;
                if (hit_msk) msk_r <= pwdata & KEEP;
            end
        end

        assign en_vec[w*WORD_W +: WORD_W]  = en_r;
        assign msk_vec[w*WORD_W +: WORD_W] = msk_r;
    end

    always_comb begin
        ctl.en  = en_vec;
        ctl.msk = msk_vec;
    end

    always_comb begin
        case (sel)
            SEL_EN_LO:  rd_mux = en_vec[WORD_W-1:0];
            SEL_EN_HI:  rd_mux = en_vec[MAX_SRC-1:WORD_W];
            SEL_MSK_LO: rd_mux = msk_vec[WORD_W-1:0];
            SEL_MSK_HI: rd_mux = msk_vec[MAX_SRC-1:WORD_W];
            SEL_ST_LO:  rd_mux = fin[WORD_W-1:0];
            SEL_ST_HI:  rd_mux = fin[MAX_SRC-1:WORD_W];
            default:    rd_mux = '0;
        endcase
    end

    assign prdata = psel ? rd_mux : '0;
endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [MAX_SRC-1:0] lvl,
    input  ctl_t               ctl,
    output logic [MAX_SRC-1:0] fin,
    output logic               irq_q
);
    assign fin = lvl & ctl.en & ~ctl.msk;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |fin;
    end
endmodule

// File: rtl/irq_agg_apb.sv
module irq_agg_apb
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_out
);
    logic [NUM_SRC-1:0] lvl_n;
    logic [MAX_SRC-1:0] lvl_w;
    logic [MAX_SRC-1:0] fin_w;
    logic [MAX_SRC-1:0] en_w;
    logic [MAX_SRC-1:0] msk_w;
    ctl_t               ctl;

    irq_agg_sync #(.W(NUM_SRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_src),
        .q   (lvl_n)
    );

    always_comb begin
        lvl_w = '0;
        lvl_w[NUM_SRC-1:0] = lvl_n;
    end

    irq_agg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .fin     (fin_w),
        .prdata  (prdata),
        .ctl     (ctl)
    );

    irq_agg_status u_stat (
        .clk   (clk),
        .rst   (rst),
        .lvl   (lvl_w),
        .ctl   (ctl),
        .fin   (fin_w),
        .irq_q (irq_out)
    );

    assign en_w    = ctl.en;
    assign msk_w   = ctl.msk;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [31:0]        pwdata,
    input logic [31:0]        prdata,
    input logic               irq_out,
    input logic [MAX_SRC-1:0] lvl_w,
    input logic [MAX_SRC-1:0] en_w,
    input logic [MAX_SRC-1:0] msk_w,
    input logic [MAX_SRC-1:0] fin_w
);
    localparam logic [MAX_SRC-1:0] IMPL = impl_bits(NUM_SRC);

    logic mapped;
    assign mapped = (paddr == ADDR_W'(OFS_EN))  || (paddr == ADDR_W'(OFS_EN + STRIDE))
                 || (paddr == ADDR_W'(OFS_MSK)) || (paddr == ADDR_W'(OFS_MSK + STRIDE))
                 || (paddr == ADDR_W'(OFS_ST))  || (paddr == ADDR_W'(OFS_ST + STRIDE));

    assert_en_write_R2: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && paddr == ADDR_W'(OFS_EN))
        |=> (en_w[31:0] == ($past(pwdata) & IMPL[31:0])));

    assert_msk_write_R3: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && paddr == ADDR_W'(OFS_MSK + STRIDE))
        |=> (msk_w[63:32] == ($past(pwdata) & IMPL[63:32])));

    assert_status_subset_R4: assert property (@(posedge clk) disable iff (rst)
        (fin_w & ~(lvl_w & en_w)) == '0);

    assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (fin_w & msk_w) == '0);

    assert_no_ghost_bits_R6: assert property (@(posedge clk) disable iff (rst)
        ((en_w | msk_w) & ~IMPL) == '0);

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
        (|(lvl_w & en_w & ~msk_w)) |=> irq_out);

    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (rst)
        !(|(lvl_w & en_w & ~msk_w)) |=> !irq_out);

    assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && !mapped) |-> (prdata == '0));
endmodule

bind irq_agg_apb irq_agg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .irq_out (irq_out),
    .lvl_w   (lvl_w),
    .en_w    (en_w),
    .msk_w   (msk_w),
    .fin_w   (fin_w)
);

// File: tb/irq_agg_apb_tb.sv
module irq_agg_apb_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 40;
    localparam int AW         = 8;

    logic            clk;
    logic            rst;
    logic            psel;
    logic            penable;
    logic            pwrite;
    logic [AW-1:0]   paddr;
    logic [31:0]     pwdata;
    logic [31:0]     prdata;
    logic            pready;
    logic            pslverr;
    logic [NSRC-1:0] irq_src;
    logic            irq_out;

    irq_agg_apb #(.NUM_SRC(NSRC), .ADDR_W(AW)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr),
        .irq_src (irq_src),
        .irq_out (irq_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  smp_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    task automatic note(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected read value when the access phase is sampled
    initial begin
        forever begin
            item_t it;
            @(smp_ev);
            if (q.size() > 0) begin
                it = q.pop_front();
                note(it.tag, prdata, it.exp);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apb_wr(logic [AW-1:0] a, logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
        item_t it;
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
        -> smp_ev;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
        irq_src = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        note("R1 irq_out after reset", 32'(irq_out), 32'h0);
        apb_rd(8'h00, 32'h0, "R1 enable low");
        apb_rd(8'h04, 32'h0, "R1 enable high");
        apb_rd(8'h08, 32'h0, "R1 mask low");
        apb_rd(8'h0C, 32'h0, "R1 mask high");
        apb_rd(8'h30, 32'h0, "R1 status low");

        // R2 enable readback
        apb_wr(8'h00, 32'hA5A5_5A5A);
        apb_rd(8'h00, 32'hA5A5_5A5A, "R2 enable low pattern");
        apb_wr(8'h04, 32'h0000_00C3);
        apb_rd(8'h04, 32'h0000_00C3, "R2 enable high pattern");

        // R6 unimplemented bits read zero (40 sources: 8 bits in high word)
        apb_wr(8'h04, 32'hFFFF_FFFF);
        apb_rd(8'h04, 32'h0000_00FF, "R6 enable high trimmed");
        apb_wr(8'h0C, 32'hFFFF_FFFF);
        apb_rd(8'h0C, 32'h0000_00FF, "R6 mask high trimmed");

        // R8 safe start: all enabled, all masked, all sources high
        apb_wr(8'h00, 32'hFFFF_FFFF);
        apb_wr(8'h08, 32'hFFFF_FFFF);
        irq_src = '1;
        tick(4);
        apb_rd(8'h30, 32'h0, "R8 status low all masked");
        apb_rd(8'h34, 32'h0, "R8 status high all masked");
        note("R8 irq_out all masked", 32'(irq_out), 32'h0);

        // R5 / R4 unmask source 3 only
        apb_wr(8'h08, 32'hFFFF_FFF7);
        apb_rd(8'h30, 32'h0000_0008, "R5 only unmasked source visible");
        apb_rd(8'h34, 32'h0, "R5 high word still masked");
        note("R9 irq_out with one source", 32'(irq_out), 32'h1);

        // R9 / R7 falling edge latency
        irq_src = '0;
        tick(2);
        note("R9 irq_out still high after two edges", 32'(irq_out), 32'h1);
        tick(1);
        note("R9 irq_out low after three edges", 32'(irq_out), 32'h0);
        apb_rd(8'h30, 32'h0, "R7 status clears when source falls");

        // R9 rising edge latency
        irq_src[3] = 1'b1;
        tick(2);
        note("R9 irq_out still low after two edges", 32'(irq_out), 32'h0);
        tick(1);
        note("R9 irq_out high after three edges", 32'(irq_out), 32'h1);
        apb_rd(8'h30, 32'h0000_0008, "R4 status follows source");

        // R7 status write ignored, level held
        apb_wr(8'h30, 32'h0);
        apb_rd(8'h30, 32'h0000_0008, "R7 status write ignored");
        tick(5);
        apb_rd(8'h30, 32'h0000_0008, "R7 status held while source high");
        apb_rd(8'h08, 32'hFFFF_FFF7, "R3 mask low readback");

        // R4 high word, source 32
        irq_src = '1;
        apb_wr(8'h0C, 32'hFFFF_FFFE);
        apb_rd(8'h0C, 32'h0000_00FE, "R3 mask high readback");
        tick(3);
        apb_rd(8'h34, 32'h0000_0001, "R4 status high source 32");

        // R10 unmapped offsets and fixed handshake
        apb_rd(8'h10, 32'h0, "R10 unmapped read 0x10");
        apb_rd(8'h38, 32'h0, "R10 unmapped read 0x38");
        apb_wr(8'h20, 32'h0000_0000);
        apb_rd(8'h00, 32'hFFFF_FFFF, "R10 unmapped write ignored");
        note("R10 pready", 32'(pready), 32'h1);
        note("R10 pslverr", 32'(pslverr), 32'h0);

        tick(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule